// File: doc/BRIEF.md
# Sixteen-Function Combinational ALU

This block is a purely combinational arithmetic-logic unit. It takes two operands, a 4-bit command and an output-enable input, and it presents one result of the same width as the operands. Commands 0 to 7 select arithmetic functions. Commands 8 to 15 select bitwise logic functions. The block holds no state, so several identical copies can sit side by side and feed a majority voter. Every copy gives the same answer for the same inputs in the same cycle.

When output enable is low, the result is forced to all zeros and is never left floating. Arithmetic wraps modulo 2^W. Multiplication keeps the low W bits of the product. Division returns the truncated quotient, and dividing by zero returns all ones.

Top module: `alu16`

## Requirements
- R1: Command 0 gives (op_a + op_b) mod 2^W.
- R2: Command 1 gives (op_a - op_b) mod 2^W.
- R3: Command 2 gives the low W bits of op_a * op_b.
- R4: Command 3 gives floor(op_a / op_b) when op_b is non-zero, and all ones when op_b is zero.
- R5: Command 4 gives (op_a + 1) mod 2^W, and command 5 gives (op_a - 1) mod 2^W.
- R6: Command 6 shifts op_a left by one bit. Command 7 shifts op_a right by one bit. Both fill the vacated bit with 0.
- R7: Commands 8, 9 and 10 give op_a AND op_b, op_a OR op_b and op_a XOR op_b.
- R8: Commands 11, 12 and 13 give the inverted AND, the inverted OR and the inverted XOR of op_a and op_b.
- R9: Command 14 gives the bitwise inverse of op_a. Command 15 passes op_a through unchanged. Both ignore op_b.
- R10: While out_en is 0, result is all zeros for every command and operand. While out_en is 1, result carries the selected function.
- R11: The result follows any change of its inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| cmd | input | 4 | Function select, 0-7 arithmetic, 8-15 logic |
| out_en | input | 1 | Presents the result when 1, forces zeros when 0 |
| result | output | W | Function output |

## Verification
The bench targets the wrap points: 0xFF + 1, 0 - 1, incrementing 0xFF and decrementing 0. A design that widened its sum or borrowed into a ninth bit would return a wrong low byte at these points. Division is exercised with op_b equal to 0, op_b greater than op_a, and op_b equal to 1. A divider that lacked the all-ones rule, or that rounded up, would differ there. The shift cases use operands with the top bit and the bottom bit set, so a rotate or a sign fill shows up as a stray 1. For the single-operand codes and for every command under out_en low, op_b is swept while the expected result stays fixed, so any leak of op_b or of the ungated value into the result is reported.

// File: rtl/alu16.sv
module alu16 #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   cmd,
  input  logic         out_en,
  output logic [W-1:0] result
);
  localparam int W2 = 2 * W;

  logic [W-1:0]  sum_v, dif_v, inc_v, dec_v, quo_v, raw;
  logic [W2-1:0] prod_v;

  assign sum_v  = op_a + op_b;
  assign dif_v  = op_a - op_b;
  assign inc_v  = op_a + W'(1);
  assign dec_v  = op_a - W'(1);
  assign prod_v = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  // restoring division; a zero divisor leaves every quotient bit set
  always_comb begin
    logic [W:0] rem;
    rem   = '0;
    quo_v = '0;
    for (int i = W - 1; i >= 0; i--) begin
      rem = {rem[W-1:0], op_a[i]};
      if (rem >= {1'b0, op_b}) begin
        rem      = rem - {1'b0, op_b};
        quo_v[i] = 1'b1;
      end
    end
  end

  always_comb begin
    case (cmd)
      4'd0:    raw = sum_v;
      4'd1:    raw = dif_v;
      4'd2:    raw = prod_v[W-1:0];
      4'd3:    raw = quo_v;
      4'd4:    raw = inc_v;
      4'd5:    raw = dec_v;
      4'd6:    raw = {op_a[W-2:0], 1'b0};
      4'd7:    raw = {1'b0, op_a[W-1:1]};
      4'd8:    raw = op_a & op_b;
      4'd9:    raw = op_a | op_b;
      4'd10:   raw = op_a ^ op_b;
      4'd11:   raw = ~(op_a & op_b);
      4'd12:   raw = ~(op_a | op_b);
      4'd13:   raw = ~(op_a ^ op_b);
      4'd14:   raw = ~op_a;
      default: raw = op_a;
    endcase
  end

  assign result = out_en ? raw : '0;

  always_comb begin
    if (cmd == 4'd0) assert_add_inverse_R1: assert (W'(raw - op_b) == op_a);
    if (cmd == 4'd1) assert_sub_inverse_R2: assert (W'(raw + op_b) == op_a);
    if (cmd == 4'd2) assert_mul_lsb_R3: assert (raw[0] == (op_a[0] & op_b[0]));
    if (cmd == 4'd3 && op_b != '0) begin
      assert_div_bounds_R4: assert ((W2'(quo_v) * W2'(op_b) <= W2'(op_a)) &&
                                    (W2'(op_a) - W2'(quo_v) * W2'(op_b) < W2'(op_b)));
    end
    if (cmd == 4'd3 && op_b == '0) assert_div_zero_R4: assert (&raw);
    if (cmd == 4'd4) assert_inc_step_R5: assert (W'(raw - W'(1)) == op_a);
    if (cmd == 4'd5) assert_dec_step_R5: assert (W'(raw + W'(1)) == op_a);
    if (cmd == 4'd6) assert_shl_double_R6: assert (raw == W'(op_a + op_a));
    if (cmd == 4'd7) assert_shr_half_R6: assert (!raw[W-1] && W'(raw + raw) == (op_a & ~W'(1)));
    if (cmd == 4'd11) assert_nand_demorgan_R8: assert (raw == (~op_a | ~op_b));
    if (cmd == 4'd12) assert_nor_demorgan_R8: assert (raw == (~op_a & ~op_b));
    if (cmd == 4'd13) assert_xnor_rel_R8: assert ((raw ^ op_a) == ~op_b);
    if (cmd == 4'd14) assert_not_rel_R9: assert (&(raw ^ op_a));
    if (out_en && cmd == 4'd15) assert_pass_R9: assert (result == op_a);
    if (result != '0) assert_gate_R10: assert (out_en);
  end
endmodule

// File: tb/alu16_bench.sv
module alu16_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] op_a, op_b, result;
  logic [3:0]   cmd;
  logic         out_en;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  alu16 #(.W(W)) u_alu16 (.op_a(op_a), .op_b(op_b), .cmd(cmd), .out_en(out_en), .result(result));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ref_model(int a, int b, int c, bit en);
    int r;
    if (!en) return 0;
    case (c)
      0: r = a + b;
      1: r = a - b;
      2: r = a * b;
      3: r = (b == 0) ? 255 : a / b;
      4: r = a + 1;
      5: r = a - 1;
      6: r = a * 2;
      7: r = a / 2;
      8: r = a & b;
      9: r = a | b;
      10: r = a ^ b;
      11: r = ~(a & b);
      12: r = ~(a | b);
      13: r = ~(a ^ b);
      14: r = ~a;
      default: r = a;
    endcase
    return r & 255;
  endfunction

  function automatic string req_of(int c, bit en);
    if (!en) return "R10";
    case (c)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8, 9, 10: return "R7";
      11, 12, 13: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply_check(int a, int b, int c, bit en);
    int exp;
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); cmd = 4'(c); out_en = en;
    #1;
    exp = ref_model(a, b, c, en);
    n_run++;
    if (int'(result) != exp) begin
      n_fail++;
      $display("FAIL %s cmd=%0d a=%0h b=%0h en=%0b actual=%0h expected=%0h",
               req_of(c, en), c, a, b, en, result, exp);
    end
  endtask

  initial begin
    int corners [8] = '{0, 1, 2, 8'h7F, 8'h80, 8'hAA, 8'hFE, 8'hFF};
    op_a = '0; op_b = '0; cmd = '0; out_en = 1'b0;
    // quiet state with the output disabled (R10)
    apply_check(0, 0, 0, 1'b0);
    // wrap points: R1 R2 R5
    apply_check(8'hFF, 1, 0, 1'b1);
    apply_check(0, 1, 1, 1'b1);
    apply_check(8'hFF, 0, 4, 1'b1);
    apply_check(0, 0, 5, 1'b1);
    // R3 product overflow, R4 divider corners
    apply_check(8'h10, 8'h10, 2, 1'b1);
    apply_check(200, 0, 3, 1'b1);
    apply_check(5, 9, 3, 1'b1);
    apply_check(8'hFF, 1, 3, 1'b1);
    apply_check(100, 7, 3, 1'b1);
    // R6 fill bits
    apply_check(8'h81, 0, 6, 1'b1);
    apply_check(8'h81, 0, 7, 1'b1);
    // exhaustive corner grid, every command, both enables (R1-style tags per command)
    foreach (corners[i])
      foreach (corners[j])
        for (int c = 0; c < 16; c++) begin
          apply_check(corners[i], corners[j], c, 1'b1);
          apply_check(corners[i], corners[j], c, 1'b0);
        end
    // R9: op_b sweep must not disturb single-operand commands
    for (int b = 0; b < 256; b += 17) begin
      apply_check(8'h3C, b, 14, 1'b1);
      apply_check(8'h3C, b, 15, 1'b1);
    end
    // R11: change inputs between checks with no clock edge in between
    @(negedge clk);
    op_a = 8'd12; op_b = 8'd3; cmd = 4'd0; out_en = 1'b1;
    #1;
    n_run++;
    if (result != 8'd15) begin
      n_fail++;
      $display("FAIL R11 first actual=%0h expected=f", result);
    end
    op_b = 8'd4;
    #1;
    n_run++;
    if (result != 8'd16) begin
      n_fail++;
      $display("FAIL R11 second actual=%0h expected=10", result);
    end
    // pseudo-random sweep
    for (int k = 0; k < 3000; k++)
      apply_check(int'($urandom_range(255)), int'($urandom_range(255)),
                  int'($urandom_range(15)), 1'($urandom_range(3) != 0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule